// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer that sits on a 16-bit register bus. Software writes a timeout in half-second steps into a control register and then sets an enable bit. From then on, a counter steps down once per half-second tick pulse. If software does not service the timer before the counter runs out, the block pulses a reset request and records the cause in a status register.

Servicing takes a two-write key at the service offset: 0x5555 and then 0xAAAA. Only a completed pair reloads the counter. The enable bit cannot be cleared once it is set. The low-power freeze option can be chosen only once after reset.

Two synchronous resets are provided. A power-on reset clears everything. A warm reset, which is what the watchdog's own request normally produces, clears everything except the timeout-cause flag, so boot code can read why the system restarted.

Top module: `wdog_top`

## Requirements
- R1: After power-on reset, every register reads 0 and `reset_out` is 0.
- R2: The control register is at byte offset 0x0. Its timeout field WT is in bits 15:8, the reset-mask bit in bit 3, enable in bit 2 and low-power freeze in bit 0. The other bits read 0, and a write reads back through this layout.
- R3: Once enable has been written as 1, later control writes cannot clear it. Only a reset clears it.
- R4: Only the first control write after a reset sets the freeze bit (bit 0). Later writes leave it unchanged.
- R5: The write that sets enable loads the counter with the WT value being written. The counter then decrements on each tick. The tick that arrives when the count is 0 is the expiry, so expiry comes on the (WT+1)th tick. On expiry, `reset_out` goes high for exactly one cycle after that clock edge, and the counter reloads from WT and keeps running.
- R6: Writing 0x5555 and then 0xAAAA to offset 0x2 reloads the counter from WT.
- R7: Any other write to offset 0x2 abandons the key sequence, which then waits for 0x5555 again, and the counter is not reloaded. A repeated 0x5555 also counts as a wrong write.
- R8: A WT write while the timer runs does not change the current count. The new value is used from the next reload onward.
- R9: While the freeze bit is 1 and `lowpwr` is high, ticks do not change the count and cannot cause an expiry.
- R10: On expiry, bit 1 of the status register (offset 0x4) is set. A warm reset does not clear it; only power-on reset does.
- R11: When the reset-mask bit is 1, an expiry does not pulse `reset_out` but still sets the status flag.
- R12: Reads of offset 0x2 and of any undefined offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset; clears all state |
| rst | input | 1 | Synchronous warm reset; clears all state except the timeout flag |
| tick | input | 1 | One-cycle pulse marking each half-second period |
| lowpwr | input | 1 | Low-power indication; freezes counting when the freeze bit is set |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte address of the register access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| reset_out | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest situations to reach are those where a change to configuration must not change the running count. Examples are a WT rewrite in the middle of a period, a broken key pair, and a tick that arrives while frozen. The count is not visible at the ports, so each of these shows up only as the exact tick on which `reset_out` fires. The stimulus therefore places ticks at counted positions around each configuration write or key write, then counts the ticks up to the expiry pulse. A behavioural model checks every cycle in between.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W  = 16;
    localparam int TO_W   = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h0;
    localparam logic [ADDR_W-1:0] OFS_SVC  = 3'h2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    localparam int BIT_FRZ  = 0;
    localparam int BIT_EN   = 2;
    localparam int BIT_MASK = 3;
    localparam int WT_LSB   = 8;
    localparam int BIT_TOUT = 1;

    typedef struct packed {
        logic [TO_W-1:0] wt;
        logic            mask;
        logic            en;
        logic            frz;
    } ctrl_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_st_t;

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[WT_LSB +: TO_W] = c.wt;
        v[BIT_MASK]       = c.mask;
        v[BIT_EN]         = c.en;
        v[BIT_FRZ]        = c.frz;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat(logic tout);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_TOUT] = tout;
        return v;
    endfunction
endpackage

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_any,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic             en_start
);
    logic frz_locked;

    assign en_start = wr && wdata[BIT_EN] && !ctrl.en;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl       <= '0;
            frz_locked <= 1'b0;
        end else if (wr) begin
            ctrl.wt   <= wdata[WT_LSB +: TO_W];
            ctrl.mask <= wdata[BIT_MASK];
            ctrl.en   <= ctrl.en | wdata[BIT_EN];
            if (!frz_locked) begin
                ctrl.frz   <= wdata[BIT_FRZ];
                frz_locked <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_any,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic             svc_done
);
    key_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        svc_done = 1'b0;
        if (wr) begin
            unique case (st_q)
                KEY_IDLE:  st_d = (wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: begin
                    st_d     = KEY_IDLE;
                    svc_done = (wdata == KEY_SECOND);
                end
                default:   st_d = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) st_q <= KEY_IDLE;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_any,
    input  logic            tick,
    input  logic            freeze,
    input  logic            en,
    input  logic            load_start,
    input  logic [TO_W-1:0] load_val,
    input  logic            reload,
    input  logic [TO_W-1:0] wt,
    output logic [TO_W-1:0] cnt,
    output logic            expire_q
);
    logic step;
    logic hit;

    assign step = en && tick && !freeze;
    assign hit  = step && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            cnt      <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= hit;
            if (load_start)  cnt <= load_val;
            else if (reload) cnt <= wt;
            else if (hit)    cnt <= wt;
            else if (step)   cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              rst,
    input  logic              tick,
    input  logic              lowpwr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              reset_out
);
    logic            rst_any;
    logic            ctrl_wr;
    logic            svc_wr;
    ctrl_t           ctrl;
    logic            en_start;
    logic            svc_done;
    logic [TO_W-1:0] cnt;
    logic            expire_q;
    logic            tout_q;
    logic            freeze;

    assign rst_any = por | rst;
    assign ctrl_wr = wr_en && (addr == OFS_CTRL);
    assign svc_wr  = wr_en && (addr == OFS_SVC);
    assign freeze  = ctrl.frz && lowpwr;

    wdog_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_any  (rst_any),
        .wr       (ctrl_wr),
        .wdata    (wdata),
        .ctrl     (ctrl),
        .en_start (en_start)
    );

    wdog_key_fsm u_key (
        .clk      (clk),
        .rst_any  (rst_any),
        .wr       (svc_wr),
        .wdata    (wdata),
        .svc_done (svc_done)
    );

    wdog_counter u_cnt (
        .clk        (clk),
        .rst_any    (rst_any),
        .tick       (tick),
        .freeze     (freeze),
        .en         (ctrl.en),
        .load_start (en_start),
        .load_val   (wdata[WT_LSB +: TO_W]),
        .reload     (svc_done),
        .wt         (ctrl.wt),
        .cnt        (cnt),
        .expire_q   (expire_q)
    );

    always_ff @(posedge clk) begin
        if (por)           tout_q <= 1'b0;
        else if (expire_q) tout_q <= 1'b1;
    end

    assign reset_out = expire_q && !ctrl.mask;

    always_comb begin
        unique case (addr)
            OFS_CTRL: rdata = pack_ctrl(ctrl);
            OFS_STAT: rdata = pack_stat(tout_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              por,
    input logic              rst,
    input logic              lowpwr,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  rdata,
    input logic              reset_out,
    input ctrl_t             ctrl,
    input logic              en_start,
    input logic              svc_done,
    input logic [TO_W-1:0]   cnt,
    input logic              tout_q
);
    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (por || rst)
        reset_out |=> !reset_out);

    // R3
    en_sticky_chk: assert property (@(posedge clk) disable iff (por || rst)
        ctrl.en |=> ctrl.en);

    // R10
    tout_hold_chk: assert property (@(posedge clk) disable iff (por)
        tout_q |=> tout_q);

    // R11
    mask_quiet_chk: assert property (@(posedge clk) disable iff (por || rst)
        ctrl.mask |-> !reset_out);

    // R9
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (por || rst)
        (ctrl.en && ctrl.frz && lowpwr && !svc_done && !en_start) |=> $stable(cnt));

    // R6
    svc_reload_chk: assert property (@(posedge clk) disable iff (por || rst)
        (svc_done && !en_start) |=> (cnt == $past(ctrl.wt)));

    // R12
    undef_zero_chk: assert property (@(posedge clk) disable iff (por || rst)
        (addr != OFS_CTRL && addr != OFS_STAT) |-> (rdata == '0));
endmodule

bind wdog_top wdog_chk i_chk (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .lowpwr    (lowpwr),
    .addr      (addr),
    .rdata     (rdata),
    .reset_out (reset_out),
    .ctrl      (ctrl),
    .en_start  (en_start),
    .svc_done  (svc_done),
    .cnt       (cnt),
    .tout_q    (tout_q)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        rst = 1'b0;
    logic        tick = 1'b0;
    logic        lowpwr = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        reset_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wdog_top i_wdog_top (
        .clk(clk), .por(por), .rst(rst), .tick(tick), .lowpwr(lowpwr),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .reset_out(reset_out)
    );

    // behavioural reference model
    int m_wt = 0, m_mask = 0, m_en = 0, m_frz = 0, m_lock = 0;
    int m_cnt = 0, m_armed = 0, m_exp = 0, m_tout = 0;

    always @(posedge clk) begin
        int nexp;
        int done_pair;
        if (por) begin
            m_wt = 0; m_mask = 0; m_en = 0; m_frz = 0; m_lock = 0;
            m_cnt = 0; m_armed = 0; m_exp = 0; m_tout = 0;
        end else begin
            if (m_exp) m_tout = 1;
            if (rst) begin
                m_wt = 0; m_mask = 0; m_en = 0; m_frz = 0; m_lock = 0;
                m_cnt = 0; m_armed = 0; m_exp = 0;
            end else begin
                nexp = (m_en && tick && !(m_frz && lowpwr) && m_cnt == 0) ? 1 : 0;
                done_pair = 0;
                if (wr_en && addr == 3'd2) begin
                    if (m_armed) begin
                        done_pair = (wdata == 16'hAAAA) ? 1 : 0;
                        m_armed = 0;
                    end else begin
                        m_armed = (wdata == 16'h5555) ? 1 : 0;
                    end
                end
                if (wr_en && addr == 3'd0 && !m_en && wdata[2])
                    m_cnt = wdata[15:8];
                else if (done_pair)
                    m_cnt = m_wt;
                else if (m_en && tick && !(m_frz && lowpwr))
                    m_cnt = (m_cnt == 0) ? m_wt : m_cnt - 1;
                if (wr_en && addr == 3'd0) begin
                    m_wt = wdata[15:8];
                    m_mask = wdata[3];
                    if (wdata[2]) m_en = 1;
                    if (!m_lock) begin m_frz = wdata[0]; m_lock = 1; end
                end
                m_exp = nexp;
            end
        end
    end

    function automatic int model_rd(input logic [2:0] a);
        if (a == 3'd0) return (m_wt << 8) | (m_mask << 3) | (m_en << 2) | m_frz;
        if (a == 3'd4) return m_tout << 1;
        return 0;
    endfunction

    always @(negedge clk) begin
        if (!done && !por) begin
            n_run++;
            if (reset_out !== (m_exp && !m_mask) || rdata !== 16'(model_rd(addr))) begin
                n_fail++;
                $display("FAIL %s model: reset_out=%0b rdata=%h expected reset_out=%0b rdata=%h",
                         cur_req, reset_out, rdata, (m_exp && !m_mask), 16'(model_rd(addr)));
            end
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1; addr = a; wdata = d;
        nxt();
        wr_en = 0; addr = 3'd0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
        addr = a; #1;
        check(req, rdata, exp);
        addr = 3'd0;
    endtask

    // one tick; returns reset_out seen after that edge
    task automatic tk(output logic ro);
        tick = 1;
        nxt();
        tick = 0;
        ro = reset_out;
    endtask

    // n ticks that must not expire
    task automatic quiet_ticks(input string req, input int n);
        logic ro;
        for (int i = 0; i < n; i++) begin
            tk(ro);
            check(req, {15'd0, ro}, 16'd0);
            nxt();
        end
    endtask

    task automatic expiring_tick(input string req);
        logic ro;
        tk(ro);
        check(req, {15'd0, ro}, 16'd1);
        nxt();
        check(req, {15'd0, reset_out}, 16'd0);
    endtask

    task automatic do_por();
        por = 1; nxt(); nxt(); por = 0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog timeout of bench");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        nxt(); nxt(); por = 0;
        cur_req = "R1";
        rd("R1", 3'd0, 16'h0000);
        rd("R1", 3'd4, 16'h0000);
        check("R1", {15'd0, reset_out}, 16'd0);
        cur_req = "R12";
        rd("R12", 3'd2, 16'h0000);
        rd("R12", 3'd6, 16'h0000);

        cur_req = "R2";
        wr(3'd0, 16'h03F8);
        rd("R2", 3'd0, 16'h0308);
        wr(3'd0, 16'h0300);
        rd("R2", 3'd0, 16'h0300);
        quiet_ticks("R2", 6);

        cur_req = "R5";
        wr(3'd0, 16'h0304);
        quiet_ticks("R5", 3);
        expiring_tick("R5");
        rd("R10", 3'd4, 16'h0002);
        quiet_ticks("R5", 3);
        expiring_tick("R5");

        cur_req = "R3";
        wr(3'd0, 16'h0300);
        rd("R3", 3'd0, 16'h0304);
        cur_req = "R4";
        wr(3'd0, 16'h0301);
        rd("R4", 3'd0, 16'h0304);

        cur_req = "R6";
        quiet_ticks("R6", 2);
        wr(3'd2, 16'h5555);
        wr(3'd2, 16'hAAAA);
        quiet_ticks("R6", 3);
        expiring_tick("R6");

        cur_req = "R7";
        quiet_ticks("R7", 2);
        wr(3'd2, 16'h5555);
        wr(3'd2, 16'h1234);
        wr(3'd2, 16'hAAAA);
        quiet_ticks("R7", 1);
        wr(3'd2, 16'h5555);
        wr(3'd2, 16'h5555);
        wr(3'd2, 16'hAAAA);
        expiring_tick("R7");

        cur_req = "R8";
        quiet_ticks("R8", 1);
        wr(3'd0, 16'h0104);
        quiet_ticks("R8", 2);
        expiring_tick("R8");
        quiet_ticks("R8", 1);
        expiring_tick("R8");

        cur_req = "R10";
        rst = 1; nxt(); rst = 0;
        rd("R10", 3'd4, 16'h0002);
        rd("R10", 3'd0, 16'h0000);
        do_por();
        rd("R10", 3'd4, 16'h0000);

        cur_req = "R9";
        wr(3'd0, 16'h0105);
        lowpwr = 1;
        quiet_ticks("R9", 5);
        lowpwr = 0;
        quiet_ticks("R9", 1);
        expiring_tick("R9");

        cur_req = "R11";
        do_por();
        wr(3'd0, 16'h000C);
        quiet_ticks("R11", 1);
        nxt();
        rd("R11", 3'd4, 16'h0002);

        nxt(); nxt();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule